// File: doc/BRIEF.md
# Cache SRAM Read Burst Sequencer

This block paces four-beat read bursts out of an external second-level cache data SRAM onto a processor bus. A one-cycle transfer-start pulse opens a burst. The block samples the cache hit input a programmable number of clocks later. It then drives the SRAM output enable, a per-beat address-advance strobe, the two low burst address bits and a one-clock transfer acknowledge for each data beat. The SRAM is only a timing target: tag lookup, data capture, writes and snooping are handled elsewhere.

Two SRAM styles are supported. Synchronous burst parts return one beat per clock. Asynchronous parts return one beat every two clocks. A one-bit first-access setting gives the SRAM either one or two clocks from output enable to valid first-beat data. In the two-clock setting, the enable is raised on the clock that ends transfer-start whenever the data bus grant is held at that point. On a hit this hides the extra clock. A transfer-start that lands in the final acknowledge cycle is taken as a pipelined follow-on burst. In asynchronous mode with the one-clock setting, that follow-on burst has a shorter first beat.

Edge numbering used below: edge 0 is the rising clock edge that samples transfer-start high. Edge n is the n-th edge after it, and "output high at edge n" means the registered output is high in the cycle that follows edge n. d is the hit delay, os is the edge at which enable rises, and F is the first-beat edge.

Top module: `l2_rdburst_seq`

## Requirements
- R1: While rst_ni is low, and after it is released with no transfer-start, oe_o, ta_o and adv_o are 0 and beat_o is 0.
- R2: Hit is sampled at edge d, where d equals hit_dly_i and code 0 is treated as 1. If it is sampled low, ta_o never rises for that burst and oe_o is 0 from edge d on.
- R3: If slow_first_i and dbg_i are both 1 at edge 0, the burst is speculative and oe_o is high from edge 0 (os=0). Otherwise oe_o rises at edge d on a hit (os=d).
- R4: In synchronous mode (async_mode_i=0), the first ta_o is at F = max(os+1+slow, d+1). This is one clock after enable with slow_first_i=0, and two clocks with slow_first_i=1, but never before edge d+1.
- R5: In asynchronous mode (async_mode_i=1), F = max(os+1+slow, d+2). For a pipelined burst with slow_first_i=0, the floor is d+1 instead, so that burst's first beat is one clock shorter.
- R6: Each burst gives exactly four one-clock ta_o pulses. They fall at F, F+1, F+2, F+3 in synchronous mode and at F, F+2, F+4, F+6 in asynchronous mode.
- R7: During the i-th acknowledge (i=0..3), beat_o equals i, in linear order. adv_o is high together with ta_o for beats 0 to 2 and low for beat 3. After the burst, beat_o is 0.
- R8: On a hit, oe_o stays high continuously from os through the final acknowledge. It is low from the edge after the final acknowledge, unless a pipelined burst starts there and is speculative.
- R9: A transfer-start sampled during the final acknowledge cycle starts a pipelined burst whose edge 0 is that same edge. A transfer-start sampled at any other time while a burst is active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ts_i | input | 1 | Transfer-start pulse |
| dbg_i | input | 1 | Data bus grant, sampled with transfer-start |
| hit_i | input | 1 | Cache hit, sampled at edge d |
| async_mode_i | input | 1 | 0 synchronous burst SRAM, 1 asynchronous SRAM |
| slow_first_i | input | 1 | 0 one-clock, 1 two-clock first access |
| hit_dly_i | input | 2 | Hit sampling delay in clocks (1..3, 0 as 1) |
| oe_o | output | 1 | SRAM output enable |
| ta_o | output | 1 | Transfer acknowledge, one clock per beat |
| adv_o | output | 1 | Burst address advance strobe |
| beat_o | output | 2 | Low burst address bits of the current beat |

## Verification
The hardest situation to reach is the pipelined follow-on burst. Its start has to land exactly in the final acknowledge cycle of a preceding hit burst, and that cycle moves with mode, latency, grant and hit delay. The bench computes that cycle arithmetically for each first burst and raises transfer-start on it. It then sweeps the follow-on burst's mode, latency, grant and delay, including the shortened asynchronous first beat. It also raises transfer-start mid-burst to show the pulse is ignored, and runs every single-burst combination of mode, latency, grant, delay and hit.

// File: rtl/l2rb_pkg.sv
package l2rb_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;

  typedef struct packed {
    logic       async_m;
    logic       slow;
    logic       spec;
    logic       pipe;
    logic [1:0] hdly;
  } burst_cfg_t;

  function automatic logic [1:0] hit_delay(input logic [1:0] code);
    return (code == 2'd0) ? 2'd1 : code;
  endfunction
endpackage

// File: rtl/l2rb_timing.sv
module l2rb_timing
  import l2rb_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int BEATS = 4
) (
  input  burst_cfg_t       cfg_i,
  input  logic [CNT_W-1:0] edge_i,
  output logic             hit_edge_o,
  output logic             beat_edge_o,
  output logic             done_edge_o
);
  logic [CNT_W-1:0] d, os, acc, flr, first, gap, last, off;
  logic             short_floor;

  always_comb begin
    d           = CNT_W'(hit_delay(cfg_i.hdly));
    os          = cfg_i.spec ? '0 : d;
    acc         = os + CNT_W'(1) + CNT_W'(cfg_i.slow);
    // pipelined async burst in fast setting loses the extra clock
    short_floor = cfg_i.pipe && !cfg_i.slow;
    flr         = d + CNT_W'(1) + CNT_W'(cfg_i.async_m && !short_floor);
    first       = (acc > flr) ? acc : flr;
    gap         = cfg_i.async_m ? CNT_W'(2) : CNT_W'(1);
    last        = first + gap * CNT_W'(BEATS - 1);
    off         = edge_i - first;
    hit_edge_o  = (edge_i == d);
    beat_edge_o = (edge_i >= first) && (edge_i <= last) && (!cfg_i.async_m || !off[0]);
    done_edge_o = (edge_i == last + CNT_W'(1));
  end
endmodule

// File: rtl/l2rb_beat_ctr.sv
module l2rb_beat_ctr #(
  parameter int BEATS  = 4,
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  output logic [BEAT_W-1:0] beat_o,
  output logic              last_o
);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

  logic [BEAT_W-1:0] beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    beat_q <= '0;
    else if (inc_i) beat_q <= (beat_q == LAST) ? '0 : beat_q + BEAT_W'(1);
  end

  assign beat_o = beat_q;
  assign last_o = (beat_q == LAST);
endmodule

// File: rtl/l2_rdburst_seq.sv
module l2_rdburst_seq
  import l2rb_pkg::*;
#(
  parameter int BEATS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ts_i,
  input  logic       dbg_i,
  input  logic       hit_i,
  input  logic       async_mode_i,
  input  logic       slow_first_i,
  input  logic [1:0] hit_dly_i,
  output logic       oe_o,
  output logic       ta_o,
  output logic       adv_o,
  output logic [1:0] beat_o
);
  localparam int BEAT_W = $clog2(BEATS);
  localparam int CNT_W  = $clog2(2 * BEATS + 8);

  seq_state_e       state_q;
  burst_cfg_t       cfg_q;
  logic [CNT_W-1:0] cnt_q, edge_idx;
  logic             oe_q, ta_q;
  logic             hit_edge, beat_edge, done_edge, last_beat;
  logic             spec_now;
  logic [BEAT_W-1:0] beat;

  assign edge_idx = cnt_q + CNT_W'(1);
  assign spec_now = slow_first_i && dbg_i;

  l2rb_timing #(.CNT_W(CNT_W), .BEATS(BEATS)) u_timing (
    .cfg_i       (cfg_q),
    .edge_i      (edge_idx),
    .hit_edge_o  (hit_edge),
    .beat_edge_o (beat_edge),
    .done_edge_o (done_edge)
  );

  l2rb_beat_ctr #(.BEATS(BEATS), .BEAT_W(BEAT_W)) u_beat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (ta_q),
    .beat_o (beat),
    .last_o (last_beat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
      ta_q    <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      ta_q <= 1'b0;
      if (ts_i) begin
        state_q <= ST_RUN;
        cnt_q   <= '0;
        cfg_q   <= '{async_m: async_mode_i, slow: slow_first_i, spec: spec_now,
                     pipe: 1'b0, hdly: hit_dly_i};
        oe_q    <= spec_now;
      end
    end else begin
      cnt_q <= edge_idx;
      if (hit_edge && !hit_i) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
        ta_q    <= 1'b0;
      end else if (done_edge) begin
        ta_q <= 1'b0;
        if (ts_i) begin
          // follow-on burst starts on this edge
          cnt_q <= '0;
          cfg_q <= '{async_m: async_mode_i, slow: slow_first_i, spec: spec_now,
                     pipe: 1'b1, hdly: hit_dly_i};
          oe_q  <= spec_now;
        end else begin
          state_q <= ST_IDLE;
          oe_q    <= 1'b0;
        end
      end else begin
        if (hit_edge) oe_q <= 1'b1;
        ta_q <= beat_edge;
      end
    end
  end

  assign oe_o   = oe_q;
  assign ta_o   = ta_q;
  assign adv_o  = ta_q && !last_beat;
  assign beat_o = 2'(beat);
endmodule

// File: rtl/l2_rdburst_seq_checker.sv
module l2_rdburst_seq_checker #(
  parameter int BEATS = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ts_i,
  input logic       oe_o,
  input logic       ta_o,
  input logic       adv_o,
  input logic [1:0] beat_o
);
  // R8: acknowledge only while the SRAM drives
  p_ta_needs_oe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ta_o |-> oe_o);

  // R4: at least one clock from enable to data
  p_no_ta_after_oe_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |=> !ta_o);

  // R7: beat index advances linearly after each acknowledge
  p_beat_advance_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ta_o |=> beat_o == 2'($past(beat_o) + 2'd1));

  // R8: enable and acknowledge close after the last beat
  p_last_closes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ta_o && beat_o == 2'(BEATS - 1) && !ts_i) |=> (!oe_o && !ta_o));

  // R7: no address advance without an acknowledge
  p_adv_with_ta_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_o |-> ta_o);
endmodule

bind l2_rdburst_seq l2_rdburst_seq_checker #(.BEATS(BEATS)) u_checker (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ts_i   (ts_i),
  .oe_o   (oe_o),
  .ta_o   (ta_o),
  .adv_o  (adv_o),
  .beat_o (beat_o)
);

// File: tb/l2_rdburst_seq_tb_top.sv
module l2_rdburst_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ts = 1'b0, dbg = 1'b0, hit = 1'b0, async_m = 1'b0, slow = 1'b0;
  logic [1:0] hdly = 2'd1;
  logic       oe, ta, adv;
  logic [1:0] beat;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  l2_rdburst_seq dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .ts_i         (ts),
    .dbg_i        (dbg),
    .hit_i        (hit),
    .async_mode_i (async_m),
    .slow_first_i (slow),
    .hit_dly_i    (hdly),
    .oe_o         (oe),
    .ta_o         (ta),
    .adv_o        (adv),
    .beat_o       (beat)
  );

  // expected {oe, ta, adv, beat} at edge k of a burst
  function automatic logic [4:0] expect_at(int am, int sl, int dg, int dc, int ht, int pp, int k);
    int d, sp, os, fl, f, g, lst, n;
    logic e_oe, e_ta, e_adv;
    logic [1:0] e_beat;
    d   = (dc == 0) ? 1 : dc;
    sp  = sl & dg;
    os  = sp ? 0 : d;
    fl  = d + 1 + ((am != 0 && !(pp != 0 && sl == 0)) ? 1 : 0);
    f   = (os + 1 + sl > fl) ? os + 1 + sl : fl;
    g   = am ? 2 : 1;
    lst = f + 3 * g;
    if (ht == 0) return {(sp != 0 && k < d), 4'b0000};
    e_oe = (k >= os && k <= lst);
    e_ta = (k >= f && k <= lst && ((k - f) % g) == 0);
    n = 0;
    for (int j = f; j < k; j++)
      if (j <= lst && ((j - f) % g) == 0) n++;
    e_beat = 2'(n % 4);
    e_adv  = e_ta && e_beat != 2'd3;
    return {e_oe, e_ta, e_adv, e_beat};
  endfunction

  function automatic int done_edge(int am, int sl, int dg, int dc, int ht, int pp);
    int d, sp, os, fl, f;
    d  = (dc == 0) ? 1 : dc;
    sp = sl & dg;
    os = sp ? 0 : d;
    fl = d + 1 + ((am != 0 && !(pp != 0 && sl == 0)) ? 1 : 0);
    f  = (os + 1 + sl > fl) ? os + 1 + sl : fl;
    return ht ? f + 3 * (am ? 2 : 1) + 1 : d;
  endfunction

  task automatic compare(string tg_oe, string tg_ta, logic [4:0] exp_v, int k);
    checks++;
    if (oe !== exp_v[4]) begin
      errors++;
      $display("FAIL %s oe k=%0d act=%b exp=%b", tg_oe, k, oe, exp_v[4]);
    end
    if (ta !== exp_v[3]) begin
      errors++;
      $display("FAIL %s ta k=%0d act=%b exp=%b", tg_ta, k, ta, exp_v[3]);
    end
    if (adv !== exp_v[2] || beat !== exp_v[1:0]) begin
      errors++;
      $display("FAIL R7 adv/beat k=%0d act=%b/%0d exp=%b/%0d", k, adv, beat, exp_v[2], exp_v[1:0]);
    end
  endtask

  // burst A, optional pipelined burst B, optional ignored start at edge ign
  task automatic run_seq(int am, int sa, int da, int ha, int hita,
                         bit pb, int sb, int db, int hb, int hitb, int ign);
    int da_end, db_end, total, base;
    string t_oe, t_ta;
    logic [4:0] ev;
    @(negedge clk);
    async_m = 1'(am); slow = 1'(sa); dbg = 1'(da); hdly = 2'(ha); hit = 1'(hita); ts = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ts = 1'b0;
    da_end = done_edge(am, sa, da, ha, hita, 0);
    db_end = done_edge(am, sb, db, hb, hitb, 1);
    base   = da_end;
    total  = (pb && hita != 0) ? da_end + db_end + 3 : da_end + 3;
    for (int k = 0; k < total; k++) begin
      if (pb && hita != 0 && k >= base) begin
        ev = expect_at(am, sb, db, hb, hitb, 1, k - base);
        t_oe = "R9 R3 R8"; t_ta = am ? "R9 R5 R6" : "R9 R4 R6";
      end else begin
        ev = expect_at(am, sa, da, ha, hita, 0, k);
        t_oe = hita ? "R3 R8" : "R2 R3";
        t_ta = (hita == 0) ? "R2" : (am ? "R5 R6" : "R4 R6");
        if (ign >= 0) t_oe = "R9 R8";
      end
      compare(t_oe, t_ta, ev, k);
      if (pb && hita != 0 && k == base - 1) begin
        slow = 1'(sb); dbg = 1'(db); hdly = 2'(hb); hit = 1'(hitb); ts = 1'b1;
      end else if (k == ign) begin
        ts = 1'b1;
      end else begin
        ts = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
    end
    ts = 1'b0;
  endtask

  initial begin
    // R1: reset state
    #(CLK_PERIOD * 2);
    @(negedge clk);
    checks++;
    if ({oe, ta, adv, beat} !== 5'b0) begin
      errors++;
      $display("FAIL R1 in reset act=%b exp=00000", {oe, ta, adv, beat});
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if ({oe, ta, adv, beat} !== 5'b0) begin
      errors++;
      $display("FAIL R1 idle act=%b exp=00000", {oe, ta, adv, beat});
    end

    // R2 R3 R4 R5 R6 R7 R8: full single-burst sweep
    for (int am = 0; am < 2; am++)
      for (int sl = 0; sl < 2; sl++)
        for (int dg = 0; dg < 2; dg++)
          for (int hd = 0; hd < 4; hd++)
            for (int ht = 0; ht < 2; ht++)
              run_seq(am, sl, dg, hd, ht, 1'b0, 0, 0, 1, 0, -1);

    // R9: pipelined follow-on bursts, incl. shortened async first beat (R5)
    for (int am = 0; am < 2; am++)
      for (int sa = 0; sa < 2; sa++)
        for (int sb = 0; sb < 2; sb++)
          for (int db = 0; db < 2; db++)
            for (int hb = 1; hb < 4; hb++)
              run_seq(am, sa, 1, 1, 1, 1'b1, sb, db, hb, 1, -1);
    run_seq(0, 0, 0, 2, 1, 1'b1, 1, 1, 2, 0, -1);  // R9 pipelined miss
    run_seq(1, 1, 1, 3, 1, 1'b1, 0, 0, 3, 0, -1);

    // R9: start pulse mid-burst is ignored
    run_seq(0, 0, 0, 1, 1, 1'b0, 0, 0, 1, 0, 2);
    run_seq(1, 1, 0, 2, 1, 1'b0, 0, 0, 1, 0, 4);
    run_seq(1, 0, 0, 3, 1, 1'b0, 0, 0, 1, 0, 6);
    run_seq(0, 1, 1, 2, 0, 1'b0, 0, 0, 1, 0, 1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog act=running exp=finished");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule